// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block produces the digital target for a boost LED driver's feedback reference, expressed in millivolts. When the enable input goes high, the target climbs from zero to its final value in 32 equal-duration levels. After the ramp it follows the final value directly. The final value comes from one of two sources. In code mode, a 5-bit brightness code is looked up in a pseudo-logarithmic table. In duty mode, a measured PWM duty word is scaled so that full duty gives 200 mV.

During the first part of start-up, the block raises a flag that asks the power stage to halve its switch current limit. It also watches two comparator outputs once per switching cycle: switch-node over-voltage, and feedback below half of regulation. If both hold on a fixed number of consecutive cycles, the block latches an open-load fault. The fault forces the reference to zero and holds until enable is taken low.

The controller has four states. IDLE is the disabled state. RAMP is the soft-start. TRACK follows the target after the ramp. TRIPPED holds a latched fault. The transitions are:
- start: IDLE to RAMP when enable is high.
- settle: RAMP to TRACK after the 32nd level has been held for its full time.
- trip: RAMP or TRACK to TRIPPED when the fault qualifier fires.
- stop: any state other than IDLE to IDLE when enable is low. Stop takes priority over trip.

Top module: `srs_ramp_seq`

## Requirements
- R1: While reset is held or enable is low, the reference is 0, and the half-limit and fault flags are 0. Taking enable low in any state gives these values one clock later.
- R2: On the clock edge that sees enable high in IDLE, the ramp begins. Level k (k = 1 to 32) is floor(target*k/32) and is held for STEP_CYC clocks. After the 32nd level the reference equals the target.
- R3: When mode_i is 1 (code mode), the target for code c is as follows: 0 mV for c = 0; 3c+2 mV for c = 1 to 12; 6c-34 mV for c = 13 to 23; 12c-172 mV for c = 24 to 31.
- R4: When mode_i is 0 (duty mode), the target is floor(duty*200/(2^DUTY_W-1)) mV, so a duty word of all ones gives 200 mV.
- R5: The half-limit flag is 1 for exactly the first HALF_CYC clocks after the ramp begins. It is 0 at all other times.
- R6: The fault latches on the clock edge of the FAULT_CYC-th consecutive strobed cycle on which both ovp_i and fb_low_i are 1. A strobed cycle on which either of them is 0 restarts the count. Clocks without a strobe leave the count unchanged.
- R7: While the fault is latched, the reference and the half-limit flag are 0 and fault_o is 1, whatever the target inputs do. Only taking enable low clears the fault, and a later enable starts a fresh ramp.
- R8: After the ramp, a change of code, duty or mode changes the reference in the same cycle, without a new ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Start (high) or shut down (low) |
| mode_i | input | 1 | 1 selects code mode, 0 selects duty mode |
| code_i | input | 5 | Brightness code |
| duty_i | input | DUTY_W | Measured PWM duty, full scale all ones |
| ovp_i | input | 1 | Switch-node over-voltage comparator |
| fb_low_i | input | 1 | Feedback below half regulation comparator |
| cycle_strobe_i | input | 1 | One-clock pulse per switching cycle |
| ref_mv_o | output | 8 | Reference target in mV |
| half_ilim_o | output | 1 | Request for half switch current limit |
| fault_o | output | 1 | Open-load shutdown latched |

## Verification
All outputs are combinational from registered state and the live target inputs. Target changes after the ramp therefore show up in the same cycle. The bench checks them a few nanoseconds after driving the inputs at a falling edge.

A change in enable or a qualifying strobe takes effect on the next rising edge. The bench checks these at the following falling edge. Counting ramp and half-limit positions from the falling edge after the start edge, position j carries level floor(j/STEP_CYC)+1, and the half-limit flag is set while j < HALF_CYC. The bench computes every expected value from those formulas and checks them at each position across the whole ramp.

// File: rtl/srs_pkg.sv
package srs_pkg;
    localparam int REF_W    = 8;
    localparam int CODE_W   = 5;
    localparam int REF_FULL = 200;
    localparam int NLEVELS  = 32;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RAMP    = 2'd1,
        ST_TRACK   = 2'd2,
        ST_TRIPPED = 2'd3
    } srs_state_t;
endpackage

// File: rtl/srs_target.sv
module srs_target
    import srs_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              mode_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic [REF_W-1:0]  tgt_o
);
    localparam int DMAX  = (1 << DUTY_W) - 1;
    localparam int PW    = DUTY_W + REF_W;

    logic [REF_W-1:0] code_mv;
    logic [REF_W-1:0] duty_mv;
    logic [PW-1:0]    duty_prod;
    logic [PW-1:0]    duty_quot;

    // piecewise code map, three segments of growing slope
    always_comb begin
        int c;
        int v;
        c = int'(code_i);
        if (c == 0)       v = 0;
        else if (c <= 12) v = 3 * c + 2;
        else if (c <= 23) v = 6 * c - 34;
        else              v = 12 * c - 172;
        code_mv = REF_W'(v);
    end

    always_comb begin
        duty_prod = PW'(duty_i) * PW'(REF_FULL);
        duty_quot = duty_prod / PW'(DMAX);
        duty_mv   = duty_quot[REF_W-1:0];
    end

    assign tgt_o = mode_i ? code_mv : duty_mv;

    always_comb begin
        AST_TARGET_RANGE: assert (tgt_o <= REF_W'(REF_FULL)); // R3
    end
endmodule

// File: rtl/srs_fault_qual.sv
module srs_fault_qual #(
    parameter int FAULT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic strobe_i,
    input  logic ovp_i,
    input  logic fb_low_i,
    output logic trip_o
);
    localparam int CW = $clog2(FAULT_CYC + 1);

    logic [CW-1:0] run_cnt;
    logic          qual;

    assign qual   = strobe_i && ovp_i && fb_low_i;
    assign trip_o = !clr_i && qual && (run_cnt == CW'(FAULT_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clr_i || trip_o) begin
            run_cnt <= '0;
        end else if (strobe_i) begin
            run_cnt <= qual ? run_cnt + 1'b1 : '0;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < CW'(FAULT_CYC)); // R6
endmodule

// File: rtl/srs_ramp_seq.sv
module srs_ramp_seq
    import srs_pkg::*;
#(
    parameter int STEP_CYC  = 10650,
    parameter int HALF_CYC  = 250000,
    parameter int FAULT_CYC = 8,
    parameter int DUTY_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              mode_i,
    input  logic [4:0]        code_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              ovp_i,
    input  logic              fb_low_i,
    input  logic              cycle_strobe_i,
    output logic [7:0]        ref_mv_o,
    output logic              half_ilim_o,
    output logic              fault_o
);
    localparam int TW = $clog2(STEP_CYC + 1);
    localparam int HW = $clog2(HALF_CYC + 1);
    localparam int SW = $clog2(NLEVELS);
    localparam int MW = REF_W + SW + 1;

    srs_state_t        state, state_nx;
    logic [SW-1:0]     step;
    logic [TW-1:0]     tick;
    logic [HW-1:0]     half_cnt;
    logic [REF_W-1:0]  tgt;
    logic              active;
    logic              trip;
    logic              level_done;
    logic [MW-1:0]     ramp_prod;

    srs_target #(.DUTY_W(DUTY_W)) u_target (
        .mode_i (mode_i),
        .code_i (code_i),
        .duty_i (duty_i),
        .tgt_o  (tgt)
    );

    srs_fault_qual #(.FAULT_CYC(FAULT_CYC)) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (!active),
        .strobe_i (cycle_strobe_i),
        .ovp_i    (ovp_i),
        .fb_low_i (fb_low_i),
        .trip_o   (trip)
    );

    assign active     = (state == ST_RAMP) || (state == ST_TRACK);
    assign level_done = (tick == TW'(STEP_CYC - 1));

    // next-state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (enable_i) state_nx = ST_RAMP;
            ST_RAMP: begin
                if (!enable_i)      state_nx = ST_IDLE;
                else if (trip)      state_nx = ST_TRIPPED;
                else if (level_done && step == SW'(NLEVELS - 1))
                                    state_nx = ST_TRACK;
            end
            ST_TRACK: begin
                if (!enable_i)      state_nx = ST_IDLE;
                else if (trip)      state_nx = ST_TRIPPED;
            end
            ST_TRIPPED: if (!enable_i) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ramp and window timers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step     <= '0;
            tick     <= '0;
            half_cnt <= '0;
        end else if (!active) begin
            step     <= '0;
            tick     <= '0;
            half_cnt <= '0;
        end else begin
            if (half_cnt != HW'(HALF_CYC)) half_cnt <= half_cnt + 1'b1;
            if (state == ST_RAMP) begin
                if (level_done) begin
                    tick <= '0;
                    if (step != SW'(NLEVELS - 1)) step <= step + 1'b1;
                end else begin
                    tick <= tick + 1'b1;
                end
            end
        end
    end

    assign ramp_prod = MW'(tgt) * (MW'(step) + MW'(1));

    // outputs
    always_comb begin
        ref_mv_o    = '0;
        half_ilim_o = 1'b0;
        fault_o     = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_RAMP: begin
                ref_mv_o    = ramp_prod[SW +: REF_W];
                half_ilim_o = (half_cnt < HW'(HALF_CYC));
            end
            ST_TRACK: begin
                ref_mv_o    = tgt;
                half_ilim_o = (half_cnt < HW'(HALF_CYC));
            end
            ST_TRIPPED: fault_o = 1'b1;
            default:    ;
        endcase
    end

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (ref_mv_o == '0 && !half_ilim_o && !fault_o)); // R1
    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && enable_i) |=> fault_o); // R7
    AST_FAULT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(cycle_strobe_i && ovp_i && fb_low_i)); // R6
    AST_HALF_NOT_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        half_ilim_o |-> (!fault_o && enable_i || $past(enable_i))); // R5
endmodule

// File: tb/srs_ramp_seq_tb.sv
module srs_ramp_seq_tb;
    localparam int STEP = 4;
    localparam int HALF = 40;
    localparam int NF   = 8;
    localparam int DW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0, mode_i = 1'b1;
    logic [4:0] code_i = '0;
    logic [DW-1:0] duty_i = '0;
    logic ovp_i = 1'b0, fb_low_i = 1'b0, cycle_strobe_i = 1'b0;
    logic [7:0] ref_mv_o;
    logic half_ilim_o, fault_o;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    srs_ramp_seq #(.STEP_CYC(STEP), .HALF_CYC(HALF), .FAULT_CYC(NF), .DUTY_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .mode_i(mode_i),
        .code_i(code_i), .duty_i(duty_i), .ovp_i(ovp_i), .fb_low_i(fb_low_i),
        .cycle_strobe_i(cycle_strobe_i), .ref_mv_o(ref_mv_o),
        .half_ilim_o(half_ilim_o), .fault_o(fault_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int code_mv(input int c);
        if (c == 0) return 0;
        if (c <= 12) return 3 * c + 2;
        if (c <= 23) return 6 * c - 34;
        return 12 * c - 172;
    endfunction

    task automatic strobe(input logic ov, input logic fl);
        @(negedge clk);
        ovp_i = ov; fb_low_i = fl; cycle_strobe_i = 1'b1;
        @(negedge clk);
        cycle_strobe_i = 1'b0;
    endtask

    task automatic run_ramp(input int tgt);
        @(negedge clk) enable_i = 1'b1;
        @(posedge clk);
        for (int j = 0; j < 32 * STEP + 4; j++) begin
            int lvl;
            @(negedge clk);
            lvl = (j / STEP) + 1;
            if (lvl > 32) lvl = 32;
            chk("R2 ramp level", int'(ref_mv_o), (tgt * lvl) / 32);
            chk("R5 half limit", int'(half_ilim_o), (j < HALF) ? 1 : 0);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #25;
        chk("R1 reset ref", int'(ref_mv_o), 0);
        chk("R1 reset half", int'(half_ilim_o), 0);
        chk("R1 reset fault", int'(fault_o), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle ref", int'(ref_mv_o), 0);

        // ramp onto code 20 (86 mV)
        mode_i = 1'b1; code_i = 5'd20;
        run_ramp(86);

        // R8 and R3: sweep all codes after ramp
        for (int c = 0; c < 32; c++) begin
            @(negedge clk) code_i = 5'(c);
            #2 chk("R3 R8 code map", int'(ref_mv_o), code_mv(c));
        end
        // R4: duty sweep
        @(negedge clk) mode_i = 1'b0;
        for (int d = 0; d < 256; d++) begin
            @(negedge clk) duty_i = DW'(d);
            #2 chk("R4 duty map", int'(ref_mv_o), (d * 200) / 255);
        end

        // R1: stop from track
        @(negedge clk) enable_i = 1'b0;
        @(negedge clk);
        chk("R1 stop ref", int'(ref_mv_o), 0);
        chk("R1 stop half", int'(half_ilim_o), 0);

        // duty-mode ramp at full duty, then stop mid-ramp
        duty_i = '1;
        @(negedge clk) enable_i = 1'b1;
        repeat (10) @(negedge clk);
        chk("R2 mid ramp level", int'(ref_mv_o), (200 * 3) / 32);
        enable_i = 1'b0;
        @(negedge clk);
        chk("R1 stop mid ramp", int'(ref_mv_o), 0);

        // full ramp in code mode to 200
        mode_i = 1'b1; code_i = 5'd31;
        run_ramp(200);

        // R6: no strobe means no counting
        @(negedge clk) ovp_i = 1'b1; fb_low_i = 1'b1;
        repeat (20) @(negedge clk);
        chk("R6 no strobe no fault", int'(fault_o), 0);
        for (int k = 0; k < NF - 1; k++) strobe(1'b1, 1'b1);
        chk("R6 one short", int'(fault_o), 0);
        strobe(1'b1, 1'b0);
        for (int k = 0; k < NF - 1; k++) strobe(1'b1, 1'b1);
        chk("R6 restart after break", int'(fault_o), 0);
        strobe(1'b0, 1'b1);
        for (int k = 0; k < NF - 1; k++) strobe(1'b1, 1'b1);
        chk("R6 restart after ovp low", int'(fault_o), 0);
        strobe(1'b1, 1'b1);
        chk("R6 trip", int'(fault_o), 1);
        chk("R7 fault ref", int'(ref_mv_o), 0);
        chk("R7 fault half", int'(half_ilim_o), 0);
        ovp_i = 1'b0; fb_low_i = 1'b0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk) code_i = 5'(c * 4);
            #2 chk("R7 held ref", int'(ref_mv_o), 0);
        end
        chk("R7 held fault", int'(fault_o), 1);
        @(negedge clk) enable_i = 1'b0;
        @(negedge clk);
        chk("R7 cleared by stop", int'(fault_o), 0);
        code_i = 5'd31;
        enable_i = 1'b1;
        @(negedge clk);
        chk("R7 restart fault", int'(fault_o), 0);
        chk("R7 restart ramp", int'(ref_mv_o), 200 / 32);
        chk("R7 restart half", int'(half_ilim_o), 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule